// File: doc/BRIEF.md
# Tick-Paced Wake Pin Debouncer

This block qualifies two external wake-up pins against a slow tick that comes from a real-time clock, rather than against the local clock. Each pin is first passed through a two-flop synchronizer. While a pin sits at its active level, a counter for that pin advances on every rising edge of the tick. Once the pin has stayed active for the number of tick periods set by a shared 3-bit period code, the block raises a wake request.

The same qualified event can also emit a one-cycle pulse that wipes the lower half of a backup register bank. The bank itself sits outside the block. For each pin, a sticky status bit records that the pin caused a wake-up. Reading the status clears these bits.

Each pin has its own enable and its own polarity select. A disabled pin never wakes the system. Period code 0 turns the debouncer off entirely.

Top module: `rtc_wake_debouncer`

## Requirements
- R1: After reset, `wake_req`, `bkp_clr` and `pin_status` are all 0.
- R2: With `period_code` = 0, no pin activity produces a wake request.
- R3: With `period_code` = c (1..7), a pin held active across c+1 tick rising edges produces a wake request. A pin held active across only c rising edges produces none.
- R4: When a pin goes inactive, its tick count restarts from zero. Two partial holds separated by a release never add up to an event.
- R5: Each activation yields at most one event, however long the pin stays active.
- R6: A pin whose `pin_en` bit is 0 never causes a wake request or sets its status bit.
- R7: `pin_pol[i]` = 1 makes pin i active-high. `pin_pol[i]` = 0 makes it active-low.
- R8: `wake_req` is a one-cycle pulse per event. `bkp_clr` pulses in the same cycle only when `clr_en` = 1, and stays 0 otherwise.
- R9: `pin_status[i]` is set when pin i causes an event and holds until a one-cycle `status_rd` clears it. If an event and a read land in the same cycle, the event wins.
- R10: Both pins are counted independently. If both qualify on the same tick, the result is one `wake_req` pulse, and both status bits end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NPIN | Raw wake-up pins, asynchronous |
| rtc_tick | input | 1 | Slow tick from the real-time clock, asynchronous |
| pin_en | input | NPIN | Per-pin enable |
| pin_pol | input | NPIN | Per-pin active level, 1 = high, 0 = low |
| period_code | input | CODE_W | 0 = off, c = c+1 tick periods required |
| clr_en | input | 1 | Allows the backup-clear pulse |
| status_rd | input | 1 | Status read strobe, clears sticky bits |
| wake_req | output | 1 | One-cycle wake request |
| bkp_clr | output | 1 | One-cycle clear pulse for lower backup half |
| pin_status | output | NPIN | Sticky per-pin wake cause |

## Verification
The hardest situations to reach are at the edges of the counting window. These are a hold that spans exactly c ticks versus exactly c+1 ticks, and a hold that is split by a brief release. Both depend on the pin level being synchronized before the first tick edge and on the tick itself being synchronized. The driver therefore sets the pin, waits out the synchronizer delay, and then emits a counted train of complete tick pulses. This makes the number of rising edges seen while the pin is active exactly the number requested. Long holds check that only one event fires. Holds with both pins together check that the two coinciding events merge into a single wake pulse.

// File: rtl/wkdb_pkg.sv
package wkdb_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  function automatic logic level_active(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction
endpackage

// File: rtl/wkdb_sync.sv
module wkdb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wkdb_pin_ctr.sv
module wkdb_pin_ctr
  import wkdb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  logic  en,
  input  code_t code,
  input  logic  tick_rise,
  output logic  evt
);
  code_t cnt_q, cnt_d;
  logic  done_q, done_d;
  logic  evt_q, evt_d;
  logic  armed;

  assign armed = en && active && (code != '0);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    evt_d  = 1'b0;
    if (!armed) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick_rise && !done_q) begin
      if (cnt_q == code) begin
        evt_d  = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/rtc_wake_debouncer.sv
module rtc_wake_debouncer
  import wkdb_pkg::*;
#(
  parameter int unsigned NPIN        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              rtc_tick,
  input  logic [NPIN-1:0]   pin_en,
  input  logic [NPIN-1:0]   pin_pol,
  input  logic [CODE_W-1:0] period_code,
  input  logic              clr_en,
  input  logic              status_rd,
  output logic              wake_req,
  output logic              bkp_clr,
  output logic [NPIN-1:0]   pin_status
);
  localparam int unsigned SW = NPIN + 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic [SW-1:0]   raw_in, sync_out;
  logic [NPIN-1:0] pin_s;
  logic            tick_s, tick_d, tick_rise;

  assign raw_in = {rtc_tick, pin_in};

  wkdb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign pin_s  = sync_out[NPIN-1:0];
  assign tick_s = sync_out[NPIN];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) tick_d <= 1'b0;
    else          tick_d <= tick_s;
  end
  assign tick_rise = tick_s & ~tick_d;

  logic [NPIN-1:0] evt;

  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      wkdb_pin_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n_i),
        .active    (level_active(pin_s[p], pin_pol[p])),
        .en        (pin_en[p]),
        .code      (period_code),
        .tick_rise (tick_rise),
        .evt       (evt[p])
      );
    end
  endgenerate

  logic [NPIN-1:0] status_q, status_d;
  always_comb begin
    status_d = status_q;
    if (status_rd) status_d = '0;
    status_d = status_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) status_q <= '0;
    else          status_q <= status_d;
  end

  assign wake_req   = |evt;
  assign bkp_clr    = clr_en & (|evt);
  assign pin_status = status_q;
endmodule

// File: rtl/wkdb_checker.sv
module wkdb_checker #(
  parameter int unsigned NPIN   = 2,
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   pin_en,
  input logic [CODE_W-1:0] period_code,
  input logic              status_rd,
  input logic              wake_req,
  input logic [NPIN-1:0]   pin_status
);
  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period_code == '0 && $past(period_code) == '0) |-> !wake_req); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0 && $past(pin_en) == '0) |-> !wake_req); // R6

  AST_WAKE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> (pin_status != '0)); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !wake_req) |=> (pin_status == '0)); // R9

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && !wake_req) |=> $stable(pin_status)); // R9

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && (pin_en == $past(pin_en))) |=> !wake_req); // R8
endmodule

bind rtc_wake_debouncer wkdb_checker #(.NPIN(NPIN), .CODE_W(wkdb_pkg::CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_en      (pin_en),
  .period_code (period_code),
  .status_rd   (status_rd),
  .wake_req    (wake_req),
  .pin_status  (pin_status)
);

// File: tb/tb_rtc_wake_debouncer.sv
module tb_rtc_wake_debouncer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin_in;
  logic       rtc_tick;
  logic [1:0] pin_en;
  logic [1:0] pin_pol;
  logic [2:0] period_code;
  logic       clr_en;
  logic       status_rd;
  logic       wake_req;
  logic       bkp_clr;
  logic [1:0] pin_status;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  rtc_wake_debouncer dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rtc_tick(rtc_tick),
    .pin_en(pin_en), .pin_pol(pin_pol), .period_code(period_code),
    .clr_en(clr_en), .status_rd(status_rd), .wake_req(wake_req),
    .bkp_clr(bkp_clr), .pin_status(pin_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every wake pulse pops one expected item (R8 clear flag)
  always @(negedge clk) begin
    if (rst_n) begin
      if (bkp_clr && !wake_req) chk("R8 clr without wake", 1, 0);
      if (wake_req) begin
        if (exp_q.size() == 0) chk("R5 unexpected wake", 1, 0);
        else chk("R8 clear pulse", int'(bkp_clr), int'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [1:0] idle_lvl();
    return ~pin_pol;
  endfunction

  // hold pins in mask active across n complete tick pulses
  task automatic hold(input logic [1:0] mask, input int n, input bit expect_evt);
    if (expect_evt) exp_q.push_back(clr_en);
    @(negedge clk);
    pin_in = idle_lvl() ^ mask;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      rtc_tick = 1'b1; repeat (4) @(negedge clk);
      rtc_tick = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    pin_in = idle_lvl();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_done(input string req);
    chk(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic read_status(input string req, input logic [1:0] exp);
    @(negedge clk);
    chk(req, pin_status, exp);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    chk("R9 cleared by read", pin_status, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rtc_tick = 1'b0; pin_en = 2'b00; pin_pol = 2'b11;
    pin_in = 2'b00; period_code = 3'd0; clr_en = 1'b0; status_rd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 wake_req reset", wake_req, 0);
    chk("R1 bkp_clr reset", bkp_clr, 0);
    chk("R1 status reset", pin_status, 0);

    // R3: code 1 needs 2 ticks
    pin_en = 2'b01; period_code = 3'd1;
    hold(2'b01, 2, 1'b1);
    expect_done("R3 code1 two ticks");
    read_status("R9 pin0 status", 2'b01);

    // R3 boundary: code 3, three ticks too few, four enough
    period_code = 3'd3;
    hold(2'b01, 3, 1'b0);
    expect_done("R3 code3 three ticks");
    read_status("R3 no status short hold", 2'b00);
    hold(2'b01, 4, 1'b1);
    expect_done("R3 code3 four ticks");
    read_status("R9 pin0 status again", 2'b01);

    // R8: clear pulse, code 7 needs 8 ticks
    clr_en = 1'b1; period_code = 3'd7;
    hold(2'b01, 8, 1'b1);
    expect_done("R8 code7 clear");
    read_status("R9 status after clear", 2'b01);
    clr_en = 1'b0;

    // R5: long hold gives exactly one event
    period_code = 3'd2;
    hold(2'b01, 12, 1'b1);
    expect_done("R5 single event");
    read_status("R5 status", 2'b01);

    // R4: split hold never completes
    period_code = 3'd3;
    hold(2'b01, 3, 1'b0);
    hold(2'b01, 3, 1'b0);
    expect_done("R4 split hold");
    read_status("R4 no status", 2'b00);

    // R2: code 0 disables
    period_code = 3'd0;
    hold(2'b01, 10, 1'b0);
    expect_done("R2 code0");
    read_status("R2 no status", 2'b00);

    // R6: disabled pin 1
    period_code = 3'd1;
    hold(2'b10, 5, 1'b0);
    expect_done("R6 disabled pin");
    read_status("R6 no status", 2'b00);

    // R7: pin 1 enabled, active-low
    pin_en = 2'b11; pin_pol = 2'b01;
    @(negedge clk); pin_in = idle_lvl();
    repeat (4) @(negedge clk);
    hold(2'b10, 2, 1'b1);
    expect_done("R7 active low");
    read_status("R7 pin1 status", 2'b10);

    // R10: both pins qualify together -> one pulse, both bits
    clr_en = 1'b1;
    hold(2'b11, 3, 1'b1);
    expect_done("R10 merged event");
    read_status("R10 both status", 2'b11);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule